// File: doc/BRIEF.md
# Split-Nibble Output Rebuilder with Alternation Watchdog

This block drives a 4-bit output port from the information bits of the telegrams addressed to one field-bus slave. In normal addressing, each accepted telegram loads all four information bits onto the port. In extended addressing, bit I3 selects the slave subtype, so only three bits are free. The port is then filled in two halves: I2 picks the upper or lower half, and I0/I1 give its two bits. Successive telegrams alternate I2, so both halves are refreshed in turn. Subtype matching is done upstream, so every strobe that reaches the block is meant for it.

A watchdog makes sure the half-select bit keeps alternating. It counts millisecond ticks since I2 last differed from its value on the previous extended-mode telegram. After 327 ticks with no change it raises a fault, and the port is forced to all zeros until I2 changes again. The watchdog runs only when it is enabled and the block is in extended mode.

The watchdog is a three-state machine. `WD_OFF` (disabled or normal mode) moves to `WD_RUN` when the watchdog becomes active. `WD_RUN` has four transitions: back to itself with the count cleared on an I2 change, back to itself with the count incremented on a tick, to `WD_FAULT` on the tick that completes the timeout, and to `WD_OFF` on deactivation. `WD_FAULT` returns to `WD_RUN` on an I2 change and goes to `WD_OFF` on deactivation.

Top module: `xaddr_out_demux`

## Requirements
- R1: After reset the output port is 0000 and the fault flag is low.
- R2: In normal mode (ext_mode=0), a strobe copies info[i] to dout[i] for i = 0..3, visible the cycle after the strobe.
- R3: In extended mode, a strobe with info[2]=0 writes info[0] to dout[0] and info[1] to dout[1]; dout[3:2] hold.
- R4: In extended mode, a strobe with info[2]=1 writes info[0] to dout[2] and info[1] to dout[3]; dout[1:0] hold. info[3] has no effect on the port in extended mode.
- R5: Without a strobe the output port holds its value.
- R6: While the watchdog is active, each tick advances a count that restarts whenever an extended-mode strobe carries an info[2] differing from the previous extended-mode strobe (initially 0). The tick that brings the count to TIMEOUT_MS (327) sets the fault flag in the next cycle.
- R7: While the fault flag is high, dout is 0000. Strobes still update the stored halves.
- R8: An extended-mode strobe with a changed info[2] clears the fault. The next cycle shows the stored data, including that strobe's write.
- R9: With wdog_en=0 or ext_mode=0, the fault flag stays low and the count is held at zero. On reactivation, counting starts from zero, and the tick in the activation cycle is not counted.
- R10: If an I2 change and the timeout-completing tick fall in the same cycle, the change wins: no fault, and the count restarts.
- R11: A strobe whose info[2] equals the previous one does not restart the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tele_stb | input | 1 | One-cycle strobe for a telegram addressed to this slave |
| info | input | 4 | Telegram information bits I0..I3 |
| ext_mode | input | 1 | Extended addressing active |
| wdog_en | input | 1 | Watchdog enable |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| dout | output | 4 | Rebuilt output port |
| wdog_fault | output | 1 | Alternation watchdog fault |

## Verification
The I2 change that restarts the watchdog and the tick that would complete the timeout can land in the same clock. The bench provokes this by counting exactly 326 ticks after a restart. It then issues a strobe with a flipped I2 together with a tick. The flag must stay low and the written half must appear. A further 327 ticks must then be needed to fault, which shows the count really restarted. A behavioural model that runs alongside judges every other cycle.

// File: rtl/xod_pkg.sv
package xod_pkg;
    typedef enum logic [1:0] {
        WD_OFF   = 2'd0,
        WD_RUN   = 2'd1,
        WD_FAULT = 2'd2
    } wd_state_e;
endpackage

// File: rtl/xod_halves.sv
module xod_halves #(
    parameter int HALF_W = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  stb,
    input  logic                  ext_mode,
    input  logic [2*HALF_W-1:0]   din,
    output logic [2*HALF_W-1:0]   q
);
    localparam int PORT_W  = 2 * HALF_W;
    localparam int SEL_IDX = HALF_W;

    logic [HALF_W-1:0] half_q [2];

    for (genvar h = 0; h < 2; h++) begin : g_half
        logic              wr;
        logic [HALF_W-1:0] nxt;
        always_comb begin
            wr  = stb && (!ext_mode || (din[SEL_IDX] == (h == 1)));
            nxt = ext_mode ? din[HALF_W-1:0] : din[h*HALF_W +: HALF_W];
        end
        always_ff @(posedge clk) begin
            if (!rst_n)  half_q[h] <= '0;
            else if (wr) half_q[h] <= nxt;
        end
    end

    always_comb q = {half_q[1], half_q[0]};

    // R5: no strobe, no change
    a_r5_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !stb |=> $stable(q));
    // R3: a lower-half write leaves the upper half alone
    a_r3_upper_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (stb && ext_mode && !din[SEL_IDX]) |=> $stable(q[PORT_W-1:HALF_W]));
    // R4: an upper-half write leaves the lower half alone
    a_r4_lower_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (stb && ext_mode && din[SEL_IDX]) |=> $stable(q[HALF_W-1:0]));
endmodule

// File: rtl/xod_watchdog.sv
module xod_watchdog
    import xod_pkg::*;
#(
    parameter int TIMEOUT_MS = 327
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic stb,
    input  logic sel,
    input  logic tick,
    output logic fault
);
    localparam int CNT_W = $clog2(TIMEOUT_MS + 1);

    wd_state_e        state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             prev_sel;
    logic             toggle, last_tick;

    always_comb begin
        toggle    = stb && (sel != prev_sel);
        last_tick = tick && (cnt_q == CNT_W'(TIMEOUT_MS - 1));
    end

    always_ff @(posedge clk) begin
        if (!rst_n)   prev_sel <= 1'b0;
        else if (stb) prev_sel <= sel;
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            WD_OFF: begin
                cnt_d = '0;
                if (enable) state_d = WD_RUN;
            end
            WD_RUN: begin
                if (!enable) begin
                    state_d = WD_OFF;
                    cnt_d   = '0;
                end else if (toggle) begin
                    cnt_d = '0;
                end else if (last_tick) begin
                    state_d = WD_FAULT;
                    cnt_d   = '0;
                end else if (tick) begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            WD_FAULT: begin
                cnt_d = '0;
                if (!enable)     state_d = WD_OFF;
                else if (toggle) state_d = WD_RUN;
            end
            default: begin
                state_d = WD_OFF;
                cnt_d   = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= WD_OFF;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb fault = (state_q == WD_FAULT);

    // R6: a fault only begins after a tick
    a_r6_fault_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fault) |-> $past(tick));
    // R6: count never reaches the limit
    a_r6_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < CNT_W'(TIMEOUT_MS));
    // R9: inactive watchdog never faults
    a_r9_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !fault);
    // R8 / R10: an alternation while active leaves no fault
    a_r8_toggle_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && toggle && state_q != WD_OFF) |=> !fault);
endmodule

// File: rtl/xaddr_out_demux.sv
module xaddr_out_demux #(
    parameter int HALF_W     = 2,
    parameter int TIMEOUT_MS = 327
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tele_stb,
    input  logic [2*HALF_W-1:0] info,
    input  logic                ext_mode,
    input  logic                wdog_en,
    input  logic                ms_tick,
    output logic [2*HALF_W-1:0] dout,
    output logic                wdog_fault
);
    localparam int PORT_W  = 2 * HALF_W;
    localparam int SEL_IDX = HALF_W;

    logic [PORT_W-1:0] held;
    logic              wd_fault;

    xod_halves #(.HALF_W(HALF_W)) u_halves (
        .clk      (clk),
        .rst_n    (rst_n),
        .stb      (tele_stb),
        .ext_mode (ext_mode),
        .din      (info),
        .q        (held)
    );

    xod_watchdog #(.TIMEOUT_MS(TIMEOUT_MS)) u_wdog (
        .clk    (clk),
        .rst_n  (rst_n),
        .enable (wdog_en && ext_mode),
        .stb    (tele_stb && ext_mode),
        .sel    (info[SEL_IDX]),
        .tick   (ms_tick),
        .fault  (wd_fault)
    );

    always_comb begin
        dout       = wd_fault ? '0 : held;
        wdog_fault = wd_fault;
    end

    // R2: normal-mode strobe shows the full word next cycle
    a_r2_full_load: assert property (@(posedge clk) disable iff (!rst_n)
        (tele_stb && !ext_mode) |=> (dout == $past(info)));
endmodule

// File: tb/sim_xaddr_out_demux.sv
module sim_xaddr_out_demux;
    localparam int TMO = 327;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tele_stb = 1'b0;
    logic [3:0] info = 4'b0;
    logic       ext_mode = 1'b0;
    logic       wdog_en = 1'b0;
    logic       ms_tick = 1'b0;
    logic [3:0] dout;
    logic       wdog_fault;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // reference model state
    logic [3:0] m_data = 4'b0;
    logic       m_prev = 1'b0;
    int         m_cnt = 0;
    logic       m_fault = 1'b0;
    bit         m_on = 1'b0;

    always #4 clk = ~clk;

    xaddr_out_demux u0 (
        .clk(clk), .rst_n(rst_n), .tele_stb(tele_stb), .info(info),
        .ext_mode(ext_mode), .wdog_en(wdog_en), .ms_tick(ms_tick),
        .dout(dout), .wdog_fault(wdog_fault)
    );

    always @(posedge clk) begin : model
        bit tg;
        bit act;
        if (!rst_n) begin
            m_data = 4'b0; m_prev = 1'b0; m_cnt = 0; m_fault = 1'b0; m_on = 1'b0;
        end else begin
            tg  = tele_stb && ext_mode && (info[2] != m_prev);
            act = wdog_en && ext_mode;
            if (!m_on) begin
                if (act) begin m_on = 1'b1; m_cnt = 0; m_fault = 1'b0; end
            end else if (!act) begin
                m_on = 1'b0; m_cnt = 0; m_fault = 1'b0;
            end else if (tg) begin
                m_cnt = 0; m_fault = 1'b0;
            end else if (!m_fault && ms_tick) begin
                m_cnt++;
                if (m_cnt == TMO) begin m_fault = 1'b1; m_cnt = 0; end
            end
            if (tele_stb) begin
                if (!ext_mode)    m_data = info;
                else if (info[2]) m_data[3:2] = info[1:0];
                else              m_data[1:0] = info[1:0];
                if (ext_mode) m_prev = info[2];
            end
        end
    end

    task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %b expected %b", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("model dout", dout, m_fault ? 4'b0 : m_data);
            chk("model fault", {3'b0, wdog_fault}, {3'b0, m_fault});
        end
    end

    task automatic cyc(input logic s, input logic [3:0] inf, input logic t);
        tele_stb = s; info = inf; ms_tick = t;
        @(negedge clk);
        tele_stb = 1'b0; ms_tick = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) cyc(1'b0, 4'b0, 1'b1);
    endtask

    initial begin : wdog_timer
        #(8 * 20000);
        if (!done) begin
            done = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog timeout actual hung expected finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cyc(1'b0, 4'b0, 1'b0);
        chk("R1 reset dout", dout, 4'b0000);
        chk("R1 reset fault", {3'b0, wdog_fault}, 4'b0);

        // normal mode
        wdog_en = 1'b1;
        cyc(1'b1, 4'b1010, 1'b0);
        chk("R2 full load a", dout, 4'b1010);
        cyc(1'b1, 4'b0101, 1'b0);
        chk("R2 full load b", dout, 4'b0101);
        cyc(1'b0, 4'b1111, 1'b0);
        chk("R5 hold", dout, 4'b0101);

        // extended mode
        ext_mode = 1'b1;
        cyc(1'b1, 4'b1011, 1'b0);
        chk("R3 lower half", dout, 4'b0111);
        cyc(1'b1, 4'b0110, 1'b0);
        chk("R4 upper half", dout, 4'b1011);
        cyc(1'b1, 4'b1110, 1'b0);
        chk("R4 I3 ignored", dout, 4'b1011);

        // timeout path
        cyc(1'b1, 4'b0000, 1'b0);
        chk("R3 restart write", dout, 4'b1000);
        for (int i = 0; i < TMO - 1; i++) cyc(1'b1, 4'b0001, 1'b1);
        chk("R11 same I2 no fault yet", {3'b0, wdog_fault}, 4'b0);
        chk("R11 data", dout, 4'b1001);
        ticks(1);
        chk("R6 fault set", {3'b0, wdog_fault}, 4'b0001);
        chk("R7 blank", dout, 4'b0000);
        cyc(1'b1, 4'b0011, 1'b0);
        chk("R7 blank during write", dout, 4'b0000);
        chk("R7 still fault", {3'b0, wdog_fault}, 4'b0001);
        cyc(1'b1, 4'b0100, 1'b0);
        chk("R8 fault cleared", {3'b0, wdog_fault}, 4'b0);
        chk("R8 stored data", dout, 4'b0011);

        // collision
        ticks(TMO - 1);
        chk("R10 pre collision", {3'b0, wdog_fault}, 4'b0);
        cyc(1'b1, 4'b0010, 1'b1);
        chk("R10 toggle wins", {3'b0, wdog_fault}, 4'b0);
        chk("R10 data", dout, 4'b0010);
        ticks(TMO - 1);
        chk("R10 restarted count", {3'b0, wdog_fault}, 4'b0);
        ticks(1);
        chk("R10 later fault", {3'b0, wdog_fault}, 4'b0001);

        // deactivation
        wdog_en = 1'b0;
        cyc(1'b0, 4'b0, 1'b0);
        chk("R9 disabled clears", {3'b0, wdog_fault}, 4'b0);
        chk("R9 data back", dout, 4'b0010);
        ticks(400);
        chk("R9 disabled no fault", {3'b0, wdog_fault}, 4'b0);
        wdog_en = 1'b1; ext_mode = 1'b0;
        cyc(1'b0, 4'b0, 1'b0);
        ticks(400);
        chk("R9 normal mode no fault", {3'b0, wdog_fault}, 4'b0);
        ext_mode = 1'b1;
        cyc(1'b0, 4'b0, 1'b1);
        ticks(TMO - 1);
        chk("R9 fresh count", {3'b0, wdog_fault}, 4'b0);
        ticks(1);
        chk("R9 fault after full window", {3'b0, wdog_fault}, 4'b0001);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule